// File: doc/BRIEF.md
# Ring-Oscillator Differential Thermal Counter

This block gives an on-die temperature reading. Two ring-oscillator pulse streams are counted over the same measurement window, and the block reports the signed difference of the two counts. The reading falls linearly as the die warms. Turning the reading into degrees is left to software, which can apply a two-point line fit for each voltage level.

The tile clock is a 1600 MHz base divided by an integer from 2 to 16. The window has to last the same time at every tile frequency. Software therefore programs one reference cycle count, defined at the slowest setting (divide-by-16). At each start the block turns that reference into the actual number of tile cycles for the divider in force, which is reference × 16 / divider. It does this with a small reciprocal lookup, not a runtime divider.

The oscillator inputs are asynchronous toggle streams. Each one is synchronised, and only its rising transitions are counted. A start pulse begins a window. A one-cycle done strobe marks the end of the window, and the new difference appears at the same moment.

Top module: `rdc_thermal_counter`

## Requirements
- R1: While reset is held and after reset is released, `done_o` is 0 and `diff_o` is 0 until the first window completes.
- R2: When `start_i` is sampled high at clock edge E, `done_o` is high in the cycle that follows edge E+N. N = floor(win_ref_i × 16 / d), where d is the clamped divider. A computed N of 0 (win_ref_i = 0) is treated as 1.
- R3: Divider values below 2 behave as 2, and values above 16 behave as 16.
- R4: `done_o` is a single-cycle pulse. In the cycle after the pulse, `done_o` is low unless a new window of length 1 also ends there.
- R5: At `done_o`, `diff_o` equals count_a − count_b as a (CNT_W+1)-bit two's complement value. Each count is the number of rising transitions on that oscillator input that are counted within the window. A transition first sampled at edge j is counted at edge j+2. It belongs to the window when edge j+2 lies in E+1 … E+N.
- R6: Each oscillator count saturates at 2^CNT_W − 1 and does not wrap.
- R7: A start pulse clears both counts. A start that arrives while a window is running abandons that window: no done pulse is produced for it, and the new window is timed from the new start.
- R8: Changes to `win_ref_i` or `clk_div_i` after the start edge have no effect on the running window. They are used only at the next start.
- R9: `diff_o` holds its value in every cycle in which `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tile clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that begins a measurement window |
| win_ref_i | input | WIN_W | Reference window length in cycles at divide-by-16 |
| clk_div_i | input | DIV_W | Current tile clock divider (2 to 16) |
| osc_a_i | input | 1 | First ring-oscillator toggle stream (asynchronous) |
| osc_b_i | input | 1 | Second ring-oscillator toggle stream (asynchronous) |
| diff_o | output | CNT_W+1 | Signed count difference count_a − count_b |
| done_o | output | 1 | One-cycle strobe at the end of a window |

## Verification
The done strobe is due exactly N cycles after the edge that samples start. The bench counts negative edges from that start edge and records the first one at which `done_o` is high, so the window length is checked to the exact cycle.

An oscillator transition driven just after edge j is counted at edge j+3. The bench therefore allows toggles only in drive slots up to N−3 cycles after the start, and holds both inputs low before each start. Its expected counts then depend only on the transitions it drove itself.

The difference is sampled in the same cycle as the done strobe. It is sampled again a few cycles later to confirm that it holds.

// File: rtl/rdc_pkg.sv
package rdc_pkg;

  // Clamp a tile divider into the supported range.
  function automatic int unsigned clamp_div(int unsigned d, int unsigned lo, int unsigned hi);
    if (d < lo) return lo;
    if (d > hi) return hi;
    return d;
  endfunction

  // Fixed-point reciprocal ceil(2^k / d). It is exact for floor(x/d) whenever x*(d-1) < 2^k.
  function automatic longint unsigned recip_const(int unsigned d, int unsigned k);
    longint unsigned one_k;
    one_k = 64'd1 << k;
    return (one_k + longint'(d) - 64'd1) / longint'(d);
  endfunction

endpackage

// File: rtl/rdc_sync_edge.sv
module rdc_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  // Stages [0] and [1] form the synchroniser; [2] is the history used for edge detection.
  logic [2:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[1:0], async_i};
  end

  assign rise_o = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/rdc_sat_counter.sv
module rdc_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] nxt_o
);
  localparam logic [W-1:0] TOP = '1;

  always_comb begin
    if (clr_i)                      nxt_o = '0;
    else if (inc_i && cnt_o != TOP) nxt_o = cnt_o + W'(1);
    else                            nxt_o = cnt_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_o <= '0;
    else        cnt_o <= nxt_o;
  end
endmodule

// File: rtl/rdc_window_ctrl.sv
module rdc_window_ctrl #(
  parameter int WIN_W  = 16,
  parameter int DIV_W  = 5,
  parameter int DIV_LO = 2,
  parameter int DIV_HI = 16,
  parameter int NW     = WIN_W + $clog2(DIV_HI + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [WIN_W-1:0] win_ref_i,
  input  logic [DIV_W-1:0] clk_div_i,
  output logic             busy_o,
  output logic [NW-1:0]    left_o,
  output logic             last_o,
  output logic             done_o
);
  localparam int FRAC_W  = NW + $clog2(DIV_HI);
  localparam int PROD_W  = NW + FRAC_W;
  localparam int NUM_DIV = DIV_HI - DIV_LO + 1;
  localparam int IDX_W   = (NUM_DIV > 1) ? $clog2(NUM_DIV) : 1;

  // Reciprocal table: one entry per legal divider.
  logic [FRAC_W-1:0] recip_lut [NUM_DIV];
  for (genvar g = 0; g < NUM_DIV; g++) begin : g_lut
    assign recip_lut[g] = FRAC_W'(rdc_pkg::recip_const(g + DIV_LO, FRAC_W));
  end

  logic [DIV_W-1:0]  div_cl;
  logic [IDX_W-1:0]  div_idx;
  logic [NW-1:0]     ref_mul;
  logic [PROD_W-1:0] prod;
  logic [NW-1:0]     scaled;
  logic [NW-1:0]     n_new;

  assign div_cl  = DIV_W'(rdc_pkg::clamp_div(int'(clk_div_i), DIV_LO, DIV_HI));
  assign div_idx = IDX_W'(div_cl - DIV_W'(DIV_LO));
  assign ref_mul = NW'(win_ref_i) * NW'(DIV_HI);
  assign prod    = PROD_W'(ref_mul) * PROD_W'(recip_lut[div_idx]);
  assign scaled  = NW'(prod >> FRAC_W);
  assign n_new   = (scaled == '0) ? NW'(1) : scaled;

  assign last_o = busy_o && (left_o == NW'(1)) && !start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      left_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= last_o;
      if (start_i) begin
        busy_o <= 1'b1;
        left_o <= n_new;
      end else if (last_o) begin
        busy_o <= 1'b0;
        left_o <= '0;
      end else if (busy_o) begin
        left_o <= left_o - NW'(1);
      end
    end
  end
endmodule

// File: rtl/rdc_thermal_counter.sv
module rdc_thermal_counter #(
  parameter int CNT_W  = 16,
  parameter int WIN_W  = 16,
  parameter int DIV_W  = 5,
  parameter int DIV_LO = 2,
  parameter int DIV_HI = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [WIN_W-1:0]        win_ref_i,
  input  logic [DIV_W-1:0]        clk_div_i,
  input  logic                    osc_a_i,
  input  logic                    osc_b_i,
  output logic signed [CNT_W:0]   diff_o,
  output logic                    done_o
);
  localparam int NW  = WIN_W + $clog2(DIV_HI + 1);
  localparam int NCH = 2;

  logic [NCH-1:0]   osc_raw;
  logic [NCH-1:0]   rise;
  logic [CNT_W-1:0] cnt_q   [NCH];
  logic [CNT_W-1:0] cnt_nxt [NCH];
  logic             busy;
  logic             win_last;
  logic [NW-1:0]    win_left;
  logic [CNT_W-1:0] cnt_a;
  logic [CNT_W-1:0] cnt_b;
  logic signed [CNT_W:0] diff_q;

  assign osc_raw = {osc_b_i, osc_a_i};

  rdc_window_ctrl #(
    .WIN_W(WIN_W), .DIV_W(DIV_W), .DIV_LO(DIV_LO), .DIV_HI(DIV_HI), .NW(NW)
  ) u_win (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .win_ref_i(win_ref_i), .clk_div_i(clk_div_i),
    .busy_o(busy), .left_o(win_left), .last_o(win_last), .done_o(done_o)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    rdc_sync_edge u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(osc_raw[g]), .rise_o(rise[g])
    );
    rdc_sat_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr_i(start_i), .inc_i(rise[g] & busy),
      .cnt_o(cnt_q[g]), .nxt_o(cnt_nxt[g])
    );
  end

  assign cnt_a = cnt_q[0];
  assign cnt_b = cnt_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        diff_q <= '0;
    else if (win_last) diff_q <= $signed({1'b0, cnt_nxt[0]}) - $signed({1'b0, cnt_nxt[1]});
  end

  assign diff_o = diff_q;
endmodule

// File: rtl/rdc_thermal_counter_chk.sv
module rdc_thermal_counter_chk #(
  parameter int CNT_W = 16,
  parameter int NW    = 21
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start_i,
  input logic                  done_o,
  input logic signed [CNT_W:0] diff_o,
  input logic                  busy,
  input logic                  win_last,
  input logic [NW-1:0]         win_left,
  input logic [CNT_W-1:0]      cnt_a,
  input logic [CNT_W-1:0]      cnt_b
);
  assert_clear_on_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (cnt_a == '0 && cnt_b == '0 && busy));

  assert_no_wrap_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> (cnt_a >= $past(cnt_a)));

  assert_no_wrap_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> (cnt_b >= $past(cnt_b)));

  assert_window_countdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start_i && win_left > NW'(1)) |=> (busy && win_left == $past(win_left) - NW'(1)));

  assert_last_gives_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    win_last |=> done_o);

  assert_done_closes_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy || $past(start_i));

  assert_diff_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(diff_o));
endmodule

bind rdc_thermal_counter rdc_thermal_counter_chk #(.CNT_W(CNT_W), .NW(NW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o), .diff_o(diff_o),
  .busy(busy), .win_last(win_last), .win_left(win_left), .cnt_a(cnt_a), .cnt_b(cnt_b)
);

// File: tb/sim_rdc_thermal_counter.sv
`timescale 1ns/1ps
module sim_rdc_thermal_counter;
  localparam int CW  = 10;
  localparam int WW  = 12;
  localparam int DW  = 5;
  localparam int SAT = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic osc_a = 1'b0;
  logic osc_b = 1'b0;
  logic [WW-1:0] win_ref = '0;
  logic [DW-1:0] clk_div = 5'd16;
  logic signed [CW:0] diff;
  logic done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rdc_thermal_counter #(.CNT_W(CW), .WIN_W(WW), .DIV_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .win_ref_i(win_ref), .clk_div_i(clk_div),
    .osc_a_i(osc_a), .osc_b_i(osc_b), .diff_o(diff), .done_o(done)
  );

  function automatic int exp_len(int win, int dv);
    int d;
    int s;
    d = (dv < 2) ? 2 : ((dv > 16) ? 16 : dv);
    s = (win * 16) / d;
    return (s == 0) ? 1 : s;
  endfunction

  function automatic int sat(int x);
    return (x > SAT) ? SAT : x;
  endfunction

  task automatic check(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // Drive slot k (just after edge E+k). Toggles are allowed only while they can still land in the window.
  task automatic drive_slot(int k, int n, int mode, inout int na, inout int nb);
    bit a;
    bit b;
    if (k <= n - 3) begin
      case (mode)
        0:       begin a = 1'($urandom % 2); b = 1'($urandom % 2); end
        1:       begin a = ~osc_a;           b = ($urandom % 4) == 0; end
        default: begin a = 1'b0;             b = ~osc_b; end
      endcase
    end else begin
      a = 1'b0;
      b = 1'b0;
    end
    if (a && !osc_a) na++;
    if (b && !osc_b) nb++;
    osc_a = a;
    osc_b = b;
  endtask

  task automatic run_window(int win, int dv, int mode, string tag);
    int n;
    int na;
    int nb;
    int seen;
    int expd;
    logic signed [CW:0] held;
    n = exp_len(win, dv);
    na = 0;
    nb = 0;
    seen = -1;
    @(negedge clk);
    win_ref = WW'(win);
    clk_div = DW'(dv);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    // R8: scramble the configuration while the window runs
    win_ref = WW'($urandom);
    clk_div = DW'($urandom);
    drive_slot(0, n, mode, na, nb);
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (done && seen < 0) seen = k;
      drive_slot(k, n, mode, na, nb);
    end
    check(seen == n, {tag, " R2 R8 done cycle"}, seen, n);
    expd = sat(na) - sat(nb);
    check(int'(diff) == expd, {tag, " R5 R6 difference"}, int'(diff), expd);
    held = diff;
    @(negedge clk);
    check(!done, {tag, " R4 one-cycle done"}, int'(done), 0);
    repeat (3) @(negedge clk);
    check(diff == held, {tag, " R9 difference held"}, int'(diff), int'(held));
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!done && diff == 0, "R1 state in reset", int'(diff), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!done && diff == 0, "R1 state after reset", int'(diff), 0);

    // Directed corner cases
    run_window(0, 16, 0, "zero window");
    run_window(1, 16, 0, "one cycle");
    run_window(1, 8, 0, "two cycles");
    run_window(7, 3, 0, "odd divider");
    run_window(5, 0, 0, "R3 divider zero");
    run_window(5, 1, 0, "R3 divider one");
    run_window(5, 31, 0, "R3 divider 31");
    run_window(5, 17, 0, "R3 divider 17");
    run_window(40, 16, 2, "negative difference");
    run_window(300, 2, 1, "R6 saturate a");
    run_window(300, 2, 2, "R6 saturate b");

    // R7: abandon a running window with a fresh start
    @(negedge clk);
    win_ref = 12'd50;
    clk_div = 5'd16;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    osc_a = 1'b1;
    @(negedge clk);
    osc_a = 1'b0;
    repeat (4) @(negedge clk);
    check(!done, "R7 no early done", int'(done), 0);
    run_window(3, 4, 0, "R7 restart");
    begin
      int extra;
      extra = 0;
      repeat (60) begin
        @(negedge clk);
        if (done) extra++;
      end
      check(extra == 0, "R7 abandoned window silent", extra, 0);
    end

    // Constrained random windows
    for (int r = 0; r < 30; r++) begin
      run_window(int'($urandom % 101), int'($urandom % 32), int'($urandom % 3), "random");
    end

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R2 actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule